// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by walking a two-level translation table in memory. A requester presents a table base and a virtual address on a valid/ready handshake. The walker then reads one descriptor word, or two, through a simple memory read port. It reports the physical address, the mapping size, the cacheable/bufferable pair, the 4-bit domain and the access-permission field. If the walk cannot complete, it reports a fault instead.

A first-level entry can describe four things: an invalid entry, a whole 1 MB region mapped directly, a pointer to a 256-entry coarse table, or a pointer to a 1024-entry fine table. Second-level entries map 64 KB, 4 KB or 1 KB pages. Fine tables are only allowed when the static `tiny_en` input is set.

The controller is a six-state machine:
- `S_IDLE`: ready for a request.
- `S_FETCH1` and `S_FETCH2`: the read request is held until the memory accepts it.
- `S_WAIT1` and `S_WAIT2`: waiting for the read data.
- `S_DONE`: a one-cycle completion pulse.

The transitions are:
- `S_IDLE` to `S_FETCH1` on an accepted request.
- `S_FETCH1` to `S_WAIT1` and `S_FETCH2` to `S_WAIT2` when `mem_ready` is high.
- `S_WAIT1` to `S_DONE` when the first-level entry is a region, a fault, or returns a memory error.
- `S_WAIT1` to `S_FETCH2` when it points to a table.
- `S_WAIT2` to `S_DONE` on returned data.
- `S_DONE` to `S_IDLE` always.

Top module: `xlat_walker`

## Requirements
- R1: `req_ready` is high only in the idle state. A request is taken when `req_valid` and `req_ready` are both high; the base, the virtual address and `tiny_en` are captured at that edge. Requests presented while busy are ignored and do not alter the walk in progress.
- R2: The first read address is the base with bits 13..0 cleared, with virtual address bits 31..20 placed at address bits 13..2.
- R3: A first-level descriptor with bits 1..0 = 00, or a memory error on either read, ends the walk with `fault` = 1. After a first-level fault or error, no second read is issued.
- R4: A first-level type 11 (fine table) while captured `tiny_en` = 0 faults with no second read. The domain is still reported.
- R5: For every first-level descriptor with a type other than 00, `domain` equals descriptor bits 8..5.
- R6: Type 10 (region) completes after one read. It gives `paddr` = {desc[31:20], va[19:0]}, `ptype` = 0, `cb` = desc[3:2] and `ap` = {6'b0, desc[11:10]}.
- R7: Type 01 (coarse) reads the second level at {desc[31:10], va[19:12], 2'b00}.
- R8: Type 11 with `tiny_en` = 1 (fine) reads the second level at {desc[31:12], va[19:10], 2'b00}.
- R9: A second-level descriptor with bits 1..0 = 00 gives `fault` = 1.
- R10: Second-level type 01 gives `ptype` = 1 and `paddr` = {d[31:16], va[15:0]}. Type 10 gives `ptype` = 2 and `paddr` = {d[31:12], va[11:0]}. Both give `ap` = d[11:4] and `cb` = d[3:2].
- R11: Second-level type 11 gives `ptype` = 3, `paddr` = {d[31:10], va[9:0]}, `ap` = {6'b0, d[5:4]} and `cb` = d[3:2].
- R12: `done` is a one-cycle pulse. The results stay unchanged until the next request is accepted. On a fault, `paddr`, `ptype`, `cb` and `ap` read zero.
- R13: `mem_req` stays high with a stable `mem_addr` until a cycle in which `mem_ready` is high. Each accepted read is answered by one `mem_rvalid` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle, request can be taken |
| req_base | input | 32 | Translation table base |
| req_vaddr | input | 32 | Virtual address to translate |
| tiny_en | input | 1 | Allow fine tables and 1 KB pages |
| mem_req | output | 1 | Descriptor read request |
| mem_addr | output | 32 | Descriptor word address |
| mem_ready | input | 1 | Memory accepts the request |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Descriptor word |
| mem_err | input | 1 | Read failed, with `mem_rvalid` |
| done | output | 1 | Walk complete, one-cycle pulse |
| fault | output | 1 | Translation fault |
| paddr | output | 32 | Physical address |
| ptype | output | 2 | 0 region, 1 large, 2 small, 3 tiny |
| cb | output | 2 | Cacheable/bufferable bits |
| domain | output | 4 | Domain number |
| ap | output | 8 | Access-permission field |

## Verification
The assertions check several properties on every cycle:
- the handshake discipline: ready only when idle, and a request held stable through memory stalls;
- the first read address formed from the captured base and virtual address;
- the single-cycle done pulse, and results held after it;
- zeroed results on a fault, and the two-bit width of the permission field for region and tiny mappings.

Descriptor decoding needs chosen memory contents, so only the bench scenarios can show it. These cover:
- each first- and second-level type code;
- the coarse and fine second-level addresses;
- the tiny-disabled fault, and memory errors at each level;
- requests ignored while busy.

// File: rtl/walker_pkg.sv
package walker_pkg;
    localparam int unsigned AW = 32;
    localparam int unsigned DW = 32;

    localparam logic [AW-1:0] BASE_MASK   = 32'hFFFF_C000;
    localparam logic [DW-1:0] REGION_MASK = 32'hFFF0_0000;
    localparam logic [DW-1:0] COARSE_MASK = 32'hFFFF_FC00;
    localparam logic [DW-1:0] FINE_MASK   = 32'hFFFF_F000;
    localparam logic [DW-1:0] LARGE_MASK  = 32'hFFFF_0000;
    localparam logic [DW-1:0] SMALL_MASK  = 32'hFFFF_F000;
    localparam logic [DW-1:0] TINY_MASK   = 32'hFFFF_FC00;

    typedef enum logic [2:0] {
        S_IDLE   = 3'd0,
        S_FETCH1 = 3'd1,
        S_WAIT1  = 3'd2,
        S_FETCH2 = 3'd3,
        S_WAIT2  = 3'd4,
        S_DONE   = 3'd5
    } walk_state_e;

    typedef enum logic [1:0] {
        L1_INVALID = 2'b00,
        L1_COARSE  = 2'b01,
        L1_REGION  = 2'b10,
        L1_FINE    = 2'b11
    } l1_kind_e;

    typedef enum logic [1:0] {
        PT_REGION = 2'd0,
        PT_LARGE  = 2'd1,
        PT_SMALL  = 2'd2,
        PT_TINY   = 2'd3
    } page_kind_e;
endpackage

// File: rtl/walk_addr_gen.sv
module walk_addr_gen
    import walker_pkg::*;
(
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] vaddr,
    input  logic [DW-1:0] desc1,
    output logic [AW-1:0] l1_addr,
    output logic [AW-1:0] l2_addr
);
    logic [AW-1:0] coarse_addr;
    logic [AW-1:0] fine_addr;

    always_comb begin
        l1_addr     = (base & BASE_MASK) | {18'b0, vaddr[31:20], 2'b00};
        coarse_addr = (desc1 & COARSE_MASK) | {22'b0, vaddr[19:12], 2'b00};
        fine_addr   = (desc1 & FINE_MASK) | {20'b0, vaddr[19:10], 2'b00};
        l2_addr     = (l1_kind_e'(desc1[1:0]) == L1_FINE) ? fine_addr : coarse_addr;
    end
endmodule

// File: rtl/walk_l1_decode.sv
module walk_l1_decode
    import walker_pkg::*;
(
    input  logic [DW-1:0] desc,
    input  logic [AW-1:0] vaddr,
    input  logic          tiny_ok,
    output l1_kind_e      kind,
    output logic          invalid,
    output logic          blocked,
    output logic          last_level,
    output logic [3:0]    dom,
    output logic [AW-1:0] reg_paddr,
    output logic [1:0]    reg_cb,
    output logic [7:0]    reg_ap
);
    always_comb begin
        kind       = l1_kind_e'(desc[1:0]);
        invalid    = (kind == L1_INVALID);
        blocked    = invalid || (kind == L1_FINE && !tiny_ok);
        last_level = blocked || (kind == L1_REGION);
        dom        = desc[8:5];
        reg_paddr  = (desc & REGION_MASK) | (vaddr & ~REGION_MASK);
        reg_cb     = desc[3:2];
        reg_ap     = {6'b0, desc[11:10]};
    end
endmodule

// File: rtl/walk_l2_decode.sv
module walk_l2_decode
    import walker_pkg::*;
(
    input  logic [DW-1:0] desc,
    input  logic [AW-1:0] vaddr,
    output logic          invalid,
    output page_kind_e    kind,
    output logic [AW-1:0] pg_paddr,
    output logic [1:0]    pg_cb,
    output logic [7:0]    pg_ap
);
    always_comb begin
        invalid  = 1'b0;
        kind     = PT_SMALL;
        pg_paddr = '0;
        pg_ap    = desc[11:4];
        pg_cb    = desc[3:2];
        unique case (desc[1:0])
            2'b00: begin
                invalid = 1'b1;
            end
            2'b01: begin
                kind     = PT_LARGE;
                pg_paddr = (desc & LARGE_MASK) | (vaddr & ~LARGE_MASK);
            end
            2'b10: begin
                kind     = PT_SMALL;
                pg_paddr = (desc & SMALL_MASK) | (vaddr & ~SMALL_MASK);
            end
            2'b11: begin
                kind     = PT_TINY;
                pg_paddr = (desc & TINY_MASK) | (vaddr & ~TINY_MASK);
                pg_ap    = {6'b0, desc[5:4]};
            end
            default: invalid = 1'b1;
        endcase
    end
endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
    import walker_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-1:0] req_base,
    input  logic [AW-1:0] req_vaddr,
    input  logic          tiny_en,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    input  logic          mem_ready,
    input  logic          mem_rvalid,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_err,
    output logic          done,
    output logic          fault,
    output logic [AW-1:0] paddr,
    output logic [1:0]    ptype,
    output logic [1:0]    cb,
    output logic [3:0]    domain,
    output logic [7:0]    ap
);
    walk_state_e   state_q, state_d;
    logic [AW-1:0] base_q, va_q;
    logic [DW-1:0] desc1_q;
    logic          tiny_q;

    logic [AW-1:0] l1_addr, l2_addr;
    l1_kind_e      l1_kind;
    logic          l1_invalid, l1_blocked, l1_last;
    logic [3:0]    l1_dom;
    logic [AW-1:0] l1_paddr;
    logic [1:0]    l1_cb;
    logic [7:0]    l1_ap;
    logic          l2_invalid;
    page_kind_e    l2_kind;
    logic [AW-1:0] l2_paddr;
    logic [1:0]    l2_cb;
    logic [7:0]    l2_ap;
    logic          accept;

    walk_addr_gen u_addr (
        .base    (base_q),
        .vaddr   (va_q),
        .desc1   (desc1_q),
        .l1_addr (l1_addr),
        .l2_addr (l2_addr)
    );

    walk_l1_decode u_l1 (
        .desc       (mem_rdata),
        .vaddr      (va_q),
        .tiny_ok    (tiny_q),
        .kind       (l1_kind),
        .invalid    (l1_invalid),
        .blocked    (l1_blocked),
        .last_level (l1_last),
        .dom        (l1_dom),
        .reg_paddr  (l1_paddr),
        .reg_cb     (l1_cb),
        .reg_ap     (l1_ap)
    );

    walk_l2_decode u_l2 (
        .desc     (mem_rdata),
        .vaddr    (va_q),
        .invalid  (l2_invalid),
        .kind     (l2_kind),
        .pg_paddr (l2_paddr),
        .pg_cb    (l2_cb),
        .pg_ap    (l2_ap)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (req_valid) state_d = S_FETCH1;
            S_FETCH1: if (mem_ready) state_d = S_WAIT1;
            S_WAIT1:  if (mem_rvalid) state_d = (mem_err || l1_last) ? S_DONE : S_FETCH2;
            S_FETCH2: if (mem_ready) state_d = S_WAIT2;
            S_WAIT2:  if (mem_rvalid) state_d = S_DONE;
            S_DONE:   state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        req_ready = (state_q == S_IDLE);
        accept    = req_ready && req_valid;
        mem_req   = (state_q == S_FETCH1) || (state_q == S_FETCH2);
        mem_addr  = (state_q == S_FETCH2) ? l2_addr : l1_addr;
        done      = (state_q == S_DONE);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q  <= '0;
            va_q    <= '0;
            tiny_q  <= 1'b0;
            desc1_q <= '0;
            fault   <= 1'b0;
            paddr   <= '0;
            ptype   <= '0;
            cb      <= '0;
            domain  <= '0;
            ap      <= '0;
        end else if (accept) begin
            base_q  <= req_base;
            va_q    <= req_vaddr;
            tiny_q  <= tiny_en;
            fault   <= 1'b0;
            paddr   <= '0;
            ptype   <= '0;
            cb      <= '0;
            domain  <= '0;
            ap      <= '0;
        end else if (state_q == S_WAIT1 && mem_rvalid) begin
            desc1_q <= mem_rdata;
            if (mem_err || l1_invalid) begin
                fault <= 1'b1;
            end else begin
                domain <= l1_dom;
                if (l1_blocked) begin
                    fault <= 1'b1;
                end else if (l1_kind == L1_REGION) begin
                    paddr <= l1_paddr;
                    ptype <= PT_REGION;
                    cb    <= l1_cb;
                    ap    <= l1_ap;
                end
            end
        end else if (state_q == S_WAIT2 && mem_rvalid) begin
            if (mem_err || l2_invalid) begin
                fault <= 1'b1;
            end else begin
                paddr <= l2_paddr;
                ptype <= l2_kind;
                cb    <= l2_cb;
                ap    <= l2_ap;
            end
        end
    end
endmodule

// File: rtl/walker_checks.sv
module walker_checks
    import walker_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic          req_ready,
    input logic          mem_req,
    input logic          mem_ready,
    input logic [AW-1:0] mem_addr,
    input logic          done,
    input logic          fault,
    input logic [AW-1:0] paddr,
    input logic [1:0]    ptype,
    input logic [1:0]    cb,
    input logic [7:0]    ap,
    input walk_state_e   state_q,
    input logic [AW-1:0] base_q,
    input logic [AW-1:0] va_q
);
    a_r1_ready_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!mem_req && !done));

    a_r2_first_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && state_q == S_FETCH1) |->
            (mem_addr[31:14] == base_q[31:14] && mem_addr[13:2] == va_q[31:20] && mem_addr[1:0] == 2'b00));

    a_r13_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)));

    a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r12_results_held: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> ($stable(paddr) && $stable(fault) && $stable(ptype) && $stable(ap)));

    a_r12_fault_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault) |-> (paddr == '0 && ptype == 2'd0 && cb == 2'd0 && ap == 8'd0));

    a_r11_narrow_ap: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !fault && (ptype == 2'd3 || ptype == 2'd0)) |-> (ap[7:2] == 6'd0));
endmodule

bind xlat_walker walker_checks u_chk (.*);

// File: tb/xlat_walker_test.sv
`timescale 1ns/1ps
module xlat_walker_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_base = '0;
    logic [31:0] req_vaddr = '0;
    logic        tiny_en = 1'b0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_ready = 1'b0;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        mem_err = 1'b0;
    logic        done, fault;
    logic [31:0] paddr;
    logic [1:0]  ptype, cb;
    logic [3:0]  domain;
    logic [7:0]  ap;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // memory model state
    logic [31:0] m_d1, m_d2;
    logic        m_e1, m_e2;
    int          m_stall, m_lat;
    int          nreads;
    logic [31:0] addr_log [4];
    bit          pend;
    int          lat_cnt, stall_cnt;

    always #4 clk = ~clk;

    xlat_walker uut (.*);

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog: actual hung, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    always @(negedge clk) begin
        mem_ready  = 1'b0;
        mem_rvalid = 1'b0;
        mem_err    = 1'b0;
        if (pend) begin
            if (lat_cnt == 0) begin
                mem_rvalid = 1'b1;
                mem_rdata  = (nreads == 1) ? m_d1 : m_d2;
                mem_err    = (nreads == 1) ? m_e1 : m_e2;
                pend       = 1'b0;
            end else lat_cnt--;
        end else if (mem_req) begin
            if (stall_cnt < m_stall) stall_cnt++;
            else begin
                mem_ready = 1'b1;
                if (nreads < 4) addr_log[nreads] = mem_addr;
                nreads++;
                pend      = 1'b1;
                lat_cnt   = m_lat;
                stall_cnt = 0;
            end
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // runs one walk; results sampled at the done cycle
    task automatic walk(input logic [31:0] b, input logic [31:0] v, input logic te,
                        input logic [31:0] d1, input logic e1, input logic [31:0] d2, input logic e2,
                        input int stall, input int lat, input bit poke);
        int n = 0;
        m_d1 = d1; m_e1 = e1; m_d2 = d2; m_e2 = e2;
        m_stall = stall; m_lat = lat; nreads = 0; stall_cnt = 0;
        addr_log[0] = 'x; addr_log[1] = 'x;
        @(negedge clk);
        req_base = b; req_vaddr = v; tiny_en = te; req_valid = 1'b1;
        @(negedge clk);
        if (poke) begin
            req_base = 32'hFFFF_FFFF; req_vaddr = 32'hFFFF_FFFF; tiny_en = ~te;
            chk("R1 ready low while busy", {31'b0, req_ready}, 32'd0);
        end else req_valid = 1'b0;
        while (!done && n < 300) begin
            @(negedge clk);
            n++;
        end
        req_valid = 1'b0;
        chk("R12 done seen", {31'b0, done}, 32'd1);
    endtask

    task automatic after_done(logic [31:0] pa_exp);
        @(negedge clk);
        chk("R12 done is one cycle", {31'b0, done}, 32'd0);
        repeat (3) @(negedge clk);
        chk("R12 result held", paddr, pa_exp);
    endtask

    task automatic t_reset();
        chk("R1 ready after reset", {31'b0, req_ready}, 32'd1);
        chk("R13 no request after reset", {31'b0, mem_req}, 32'd0);
        chk("R12 no done after reset", {31'b0, done}, 32'd0);
    endtask

    task automatic t_region();
        logic [31:0] b = 32'h1234_5678, v = 32'hABC1_2345;
        logic [31:0] d = 32'h8760_094E; // type 10, cb 11, dom A, ap 10
        walk(b, v, 1'b0, d, 1'b0, 32'h0, 1'b0, 2, 1, 1'b0);
        chk("R2 first address", addr_log[0], {b[31:14], v[31:20], 2'b00});
        chk("R6 single read", nreads, 1);
        chk("R6 paddr", paddr, {d[31:20], v[19:0]});
        chk("R6 ptype", {30'b0, ptype}, 0);
        chk("R6 cb", {30'b0, cb}, 3);
        chk("R6 ap", {24'b0, ap}, 2);
        chk("R5 domain", {28'b0, domain}, 4'hA);
        chk("R12 no fault", {31'b0, fault}, 0);
        after_done({d[31:20], v[19:0]});
    endtask

    task automatic t_coarse_small();
        logic [31:0] b = 32'h0000_8000, v = 32'h0045_6789;
        logic [31:0] d1 = 32'h0030_1C61; // coarse, dom 3
        logic [31:0] d2 = 32'h7777_7A5A; // small, ap A5, cb 10
        walk(b, v, 1'b0, d1, 1'b0, d2, 1'b0, 0, 0, 1'b0);
        chk("R2 first address", addr_log[0], {b[31:14], v[31:20], 2'b00});
        chk("R7 coarse address", addr_log[1], {d1[31:10], v[19:12], 2'b00});
        chk("R10 small paddr", paddr, {d2[31:12], v[11:0]});
        chk("R10 small ptype", {30'b0, ptype}, 2);
        chk("R10 small ap", {24'b0, ap}, 8'hA5);
        chk("R10 small cb", {30'b0, cb}, 2);
        chk("R5 domain coarse", {28'b0, domain}, 3);
    endtask

    task automatic t_coarse_large();
        logic [31:0] v = 32'hFFF3_BEEF;
        logic [31:0] d1 = 32'h4000_0001;
        logic [31:0] d2 = 32'h9ABC_03C5; // large, ap 3C, cb 01
        walk(32'hC000_0000, v, 1'b1, d1, 1'b0, d2, 1'b0, 1, 2, 1'b0);
        chk("R10 large paddr", paddr, {d2[31:16], v[15:0]});
        chk("R10 large ptype", {30'b0, ptype}, 1);
        chk("R10 large ap", {24'b0, ap}, 8'h3C);
        chk("R10 large cb", {30'b0, cb}, 1);
    endtask

    task automatic t_fine_tiny();
        logic [31:0] v = 32'h0127_ABCD;
        logic [31:0] d1 = 32'h5555_51E3; // fine, dom F
        logic [31:0] d2 = 32'h1357_9FFF; // tiny, ap 11
        walk(32'h0, v, 1'b1, d1, 1'b0, d2, 1'b0, 0, 0, 1'b1);
        chk("R1 busy request ignored, first address", addr_log[0], {18'b0, v[31:20], 2'b00});
        chk("R8 fine address", addr_log[1], {d1[31:12], v[19:10], 2'b00});
        chk("R11 tiny paddr", paddr, {d2[31:10], v[9:0]});
        chk("R11 tiny ptype", {30'b0, ptype}, 3);
        chk("R11 tiny ap", {24'b0, ap}, 3);
        chk("R11 tiny cb", {30'b0, cb}, 3);
        chk("R5 domain fine", {28'b0, domain}, 4'hF);
        @(negedge clk);
        chk("R1 no restart after busy request", {31'b0, req_ready}, 1);
    endtask

    task automatic t_fine_blocked();
        walk(32'h0, 32'h0127_ABCD, 1'b0, 32'h5555_50C3, 1'b0, 32'h1357_9FFF, 1'b0, 0, 0, 1'b0);
        chk("R4 fault", {31'b0, fault}, 1);
        chk("R4 one read", nreads, 1);
        chk("R4 domain kept", {28'b0, domain}, 6);
        chk("R12 fault paddr zero", paddr, 0);
    endtask

    task automatic t_l1_invalid();
        walk(32'h0001_0000, 32'h8000_0000, 1'b1, 32'hFFFF_FFFC, 1'b0, 32'h0, 1'b0, 0, 1, 1'b0);
        chk("R3 invalid fault", {31'b0, fault}, 1);
        chk("R3 no second read", nreads, 1);
    endtask

    task automatic t_l1_error();
        walk(32'h0001_0000, 32'h8000_0000, 1'b1, 32'h8000_0002, 1'b1, 32'h0, 1'b0, 0, 0, 1'b0);
        chk("R3 first error fault", {31'b0, fault}, 1);
        chk("R3 error no second read", nreads, 1);
        chk("R12 fault ptype zero", {30'b0, ptype}, 0);
    endtask

    task automatic t_l2_invalid();
        walk(32'h0, 32'h0010_0000, 1'b0, 32'h0000_0401, 1'b0, 32'hFFFF_FFF0, 1'b0, 0, 0, 1'b0);
        chk("R9 second invalid fault", {31'b0, fault}, 1);
        chk("R9 two reads", nreads, 2);
        chk("R12 fault ap zero", {24'b0, ap}, 0);
    endtask

    task automatic t_l2_error();
        walk(32'h0, 32'h0010_0000, 1'b0, 32'h0000_0401, 1'b0, 32'h1234_5672, 1'b1, 0, 0, 1'b0);
        chk("R3 second error fault", {31'b0, fault}, 1);
        chk("R3 second error paddr zero", paddr, 0);
    endtask

    initial begin
        pend = 1'b0; nreads = 0; lat_cnt = 0; stall_cnt = 0;
        m_stall = 0; m_lat = 0; m_d1 = '0; m_d2 = '0; m_e1 = 0; m_e2 = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_region();
        t_coarse_small();
        t_coarse_large();
        t_fine_tiny();
        t_fine_blocked();
        t_l1_invalid();
        t_l1_error();
        t_l2_invalid();
        t_l2_error();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule